// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block produces the effective address and the pointer write-back value for one data write per cycle. When bit reversal is switched on and the access qualifies, the pointer's word index is combined with a pivot modifier using reverse-carry addition. The carry runs from the most significant bit down toward bit 0. Repeated post-increment writes therefore land in bit-reversed order inside a power-of-two buffer, which is the reordering a radix-2 FFT needs. An access that does not qualify gets the normal address for its mode.

The pivot is half the buffer length in words. For example, a pivot of 8 reorders a 16-word (32-byte) buffer. The block also checks the buffer configuration and raises a flag that tells the write path to skip modulo correction while reversal is in use. All results are registered and appear one clock after the request.

Top module: `bitrev_agu`

## Requirements
- R1: Reversal is active only when all of these hold: `in_rev_en`=1, `in_is_write`=1, `in_is_byte`=0, `in_sel` is not 15 (the stack pointer), and `in_mode` is 2 (post-increment) or 4 (pre-increment).
- R2: A read, a byte write, a stack-pointer access, any other mode, or `in_rev_en`=0 each produce exactly the normal address of R3, with `out_rev_active`=0.
- R3: The normal modes are encoded in `in_mode` as follows, with step = 1 for byte accesses and 2 for word accesses.
  - 0, indirect: ea=ptr, no write-back.
  - 1, post-decrement: ea=ptr, wb=ptr-step.
  - 2, post-increment: ea=ptr, wb=ptr+step.
  - 3, pre-decrement: ea=wb=ptr-step.
  - 4, pre-increment: ea=wb=ptr+step.
  - 5, offset: ea=ptr+`in_ofs`, no write-back.
  - Sums wrap modulo 2^16.
- R4: When active, the write-back is {S,0}. S is the 15-bit reverse-carry sum of ptr[15:1] and `in_pivot`: bits are added from bit 14 down to bit 0, with each carry passed to the next lower bit and the carry out of bit 0 dropped. The normal step and `in_ofs` are ignored.
- R5: When active in post-increment, ea = ptr with bit 0 cleared, and wb = {S,0} with `out_wb_en`=1.
- R6: When active in pre-increment, ea = wb = {S,0} with `out_wb_en`=1.
- R7: When active with a power-of-two pivot 2^k, bits 15..k+2 of the write-back equal the same bits of the pointer.
- R8: `out_mod_inhibit` is 1 exactly when reversal is active.
- R9: `out_cfg_err` is 1 when reversal is active and either of these holds:
  - the pivot is not a power of two (zero included), or
  - the low N bits of `in_buf_base` are not all zero, where 2^N = 4*pivot is the buffer size in bytes.
- R10: All outputs are registered one cycle after the request. `out_valid` follows `in_valid`. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_is_write | input | 1 | 1 = data write, 0 = read |
| in_is_byte | input | 1 | 1 = byte access, 0 = word access |
| in_mode | input | 3 | Addressing mode code (R3) |
| in_sel | input | 4 | Index of the selected pointer register |
| in_ptr | input | 16 | Current pointer value |
| in_ofs | input | 16 | Offset for mode 5 |
| in_rev_en | input | 1 | Bit-reversal enable |
| in_pivot | input | 15 | Reversal modifier (half buffer length in words) |
| in_buf_base | input | 16 | Buffer start byte address |
| out_valid | output | 1 | Result valid |
| out_ea | output | 16 | Effective address |
| out_wb | output | 16 | Pointer write-back value |
| out_wb_en | output | 1 | Write-back required |
| out_rev_active | output | 1 | Reversal was applied |
| out_mod_inhibit | output | 1 | Suppress modulo correction on the write path |
| out_cfg_err | output | 1 | Buffer configuration error |

## Verification
Every result is due exactly one rising edge after its request is driven. The bench drives each request on a falling edge and samples all outputs one time unit after the next rising edge. It never looks earlier or later than that edge.

A chained sequence feeds each registered write-back into the next request. This checks the bit-reversed visiting order one cycle at a time. The expected reverse-carry sums come from a bit-serial ripple computed in the bench.

// File: rtl/brev_pkg.sv
package brev_pkg;

  typedef enum logic [2:0] {
    AM_IND     = 3'd0,
    AM_POSTDEC = 3'd1,
    AM_POSTINC = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_PREINC  = 3'd4,
    AM_OFS     = 3'd5
  } agu_mode_e;

  // Mask covering the pivot's highest set bit and every bit below it.
  function automatic logic [14:0] span_mask(input logic [14:0] piv);
    logic [14:0] m;
    m = '0;
    for (int i = 0; i < 15; i++) begin
      if (piv[i]) m = 15'((32'd2 << i) - 32'd1);
    end
    return m;
  endfunction

endpackage

// File: rtl/brev_core.sv
module brev_core #(
  parameter int IW = 15
) (
  input  logic [IW-1:0] idx,
  input  logic [IW-1:0] modifier,
  output logic [IW-1:0] sum
);
  logic [IW-1:0] idx_r, mod_r, sum_r;

  // Mirror both operands, add with an ordinary carry, then mirror back.
  // In the original bit order this carries from the top bit downward.
  for (genvar g = 0; g < IW; g++) begin : g_mirror
    assign idx_r[g] = idx[IW-1-g];
    assign mod_r[g] = modifier[IW-1-g];
    assign sum[g]   = sum_r[IW-1-g];
  end

  assign sum_r = idx_r + mod_r;
endmodule

// File: rtl/brev_qualify.sv
module brev_qualify #(
  parameter int AW     = 16,
  parameter int SELW   = 4,
  parameter int SP_IDX = 15
) (
  input  logic            rev_en,
  input  logic            is_write,
  input  logic            is_byte,
  input  logic [2:0]      mode,
  input  logic [SELW-1:0] sel,
  input  logic [AW-2:0]   pivot,
  input  logic [AW-1:0]   buf_base,
  output logic            active,
  output logic            post,
  output logic            cfg_err
);
  import brev_pkg::*;
  localparam int IW = AW - 1;
  localparam int BW = IW + 2;

  logic          inc_mode;
  logic          piv_pow2;
  logic [BW-1:0] buf_bytes;
  logic [BW-1:0] base_mask;
  logic [BW-1:0] base_ext;

  assign inc_mode = (mode == AM_POSTINC) || (mode == AM_PREINC);
  assign active   = rev_en && is_write && !is_byte && inc_mode &&
                    (sel != SELW'(SP_IDX));
  assign post     = (mode == AM_POSTINC);

  // Buffer size in bytes is four times the pivot; its start must be aligned to it.
  assign piv_pow2  = (pivot != '0) && ((pivot & (pivot - 1'b1)) == '0);
  assign buf_bytes = {pivot, 2'b00};
  assign base_mask = buf_bytes - 1'b1;
  assign base_ext  = BW'(buf_base);
  assign cfg_err   = active && (!piv_pow2 || ((base_ext & base_mask) != '0));
endmodule

// File: rtl/normal_agu.sv
module normal_agu #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] ofs,
  input  logic [2:0]    mode,
  input  logic          is_byte,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb,
  output logic          wb_en
);
  import brev_pkg::*;
  logic [AW-1:0] step, up, dn;

  assign step = is_byte ? AW'(1) : AW'(2);
  assign up   = ptr + step;
  assign dn   = ptr - step;

  always_comb begin
    ea    = ptr;
    wb    = ptr;
    wb_en = 1'b0;
    case (mode)
      AM_POSTDEC: begin wb = dn; wb_en = 1'b1; end
      AM_POSTINC: begin wb = up; wb_en = 1'b1; end
      AM_PREDEC:  begin ea = dn; wb = dn; wb_en = 1'b1; end
      AM_PREINC:  begin ea = up; wb = up; wb_en = 1'b1; end
      AM_OFS:     ea = ptr + ofs;
      default:    ;
    endcase
  end
endmodule

// File: rtl/bitrev_agu.sv
module bitrev_agu #(
  parameter int AW     = 16,
  parameter int SELW   = 4,
  parameter int SP_IDX = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_is_write,
  input  logic            in_is_byte,
  input  logic [2:0]      in_mode,
  input  logic [SELW-1:0] in_sel,
  input  logic [AW-1:0]   in_ptr,
  input  logic [AW-1:0]   in_ofs,
  input  logic            in_rev_en,
  input  logic [AW-2:0]   in_pivot,
  input  logic [AW-1:0]   in_buf_base,
  output logic            out_valid,
  output logic [AW-1:0]   out_ea,
  output logic [AW-1:0]   out_wb,
  output logic            out_wb_en,
  output logic            out_rev_active,
  output logic            out_mod_inhibit,
  output logic            out_cfg_err
);
  import brev_pkg::*;
  localparam int IW = AW - 1;

  logic          act_w, post_w, err_w;
  logic [IW-1:0] sum_w;
  logic [AW-1:0] n_ea, n_wb;
  logic          n_wb_en;
  logic [AW-1:0] nx_ea, nx_wb;
  logic          nx_wb_en;

  brev_qualify #(.AW(AW), .SELW(SELW), .SP_IDX(SP_IDX)) u_qual (
    .rev_en(in_rev_en), .is_write(in_is_write), .is_byte(in_is_byte),
    .mode(in_mode), .sel(in_sel), .pivot(in_pivot), .buf_base(in_buf_base),
    .active(act_w), .post(post_w), .cfg_err(err_w)
  );

  brev_core #(.IW(IW)) u_core (
    .idx(in_ptr[AW-1:1]), .modifier(in_pivot), .sum(sum_w)
  );

  normal_agu #(.AW(AW)) u_norm (
    .ptr(in_ptr), .ofs(in_ofs), .mode(in_mode), .is_byte(in_is_byte),
    .ea(n_ea), .wb(n_wb), .wb_en(n_wb_en)
  );

  always_comb begin
    if (act_w) begin
      nx_wb    = {sum_w, 1'b0};
      nx_ea    = post_w ? {in_ptr[AW-1:1], 1'b0} : {sum_w, 1'b0};
      nx_wb_en = 1'b1;
    end else begin
      nx_wb    = n_wb;
      nx_ea    = n_ea;
      nx_wb_en = n_wb_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_ea          <= '0;
      out_wb          <= '0;
      out_wb_en       <= 1'b0;
      out_rev_active  <= 1'b0;
      out_mod_inhibit <= 1'b0;
      out_cfg_err     <= 1'b0;
    end else begin
      out_valid       <= in_valid;
      out_ea          <= nx_ea;
      out_wb          <= nx_wb;
      out_wb_en       <= nx_wb_en;
      out_rev_active  <= act_w;
      out_mod_inhibit <= act_w;
      out_cfg_err     <= err_w;
    end
  end

  // R10: the valid flag trails the request by one edge.
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1: a reversed result only follows a qualifying request.
  assert_active_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_rev_active |-> $past(in_rev_en && in_is_write && !in_is_byte &&
                             (in_sel != SELW'(SP_IDX))));

  // R2: byte accesses never take the reversed path.
  assert_byte_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_is_byte) |-> !out_rev_active);

  // R5: reversed addresses are always word aligned.
  assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_rev_active |-> (out_ea[0] == 1'b0) && (out_wb[0] == 1'b0) && out_wb_en);

  // R7: the reverse-carry adder leaves bits above the pivot untouched.
  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_w && $onehot(in_pivot)) |->
      (((sum_w ^ in_ptr[AW-1:1]) & ~span_mask(in_pivot)) == '0));

  // R8: modulo suppression tracks the previous cycle's qualification.
  assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_w |=> out_mod_inhibit);
endmodule

// File: tb/tb_bitrev_agu.sv
module tb_bitrev_agu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_is_write = 1'b0, in_is_byte = 1'b0, in_rev_en = 1'b0;
  logic [2:0]  in_mode = '0;
  logic [3:0]  in_sel = '0;
  logic [15:0] in_ptr = '0, in_ofs = '0, in_buf_base = '0;
  logic [14:0] in_pivot = '0;
  logic        out_valid, out_wb_en, out_rev_active, out_mod_inhibit, out_cfg_err;
  logic [15:0] out_ea, out_wb;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitrev_agu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_write(in_is_write),
    .in_is_byte(in_is_byte), .in_mode(in_mode), .in_sel(in_sel), .in_ptr(in_ptr),
    .in_ofs(in_ofs), .in_rev_en(in_rev_en), .in_pivot(in_pivot),
    .in_buf_base(in_buf_base), .out_valid(out_valid), .out_ea(out_ea),
    .out_wb(out_wb), .out_wb_en(out_wb_en), .out_rev_active(out_rev_active),
    .out_mod_inhibit(out_mod_inhibit), .out_cfg_err(out_cfg_err)
  );

  // Bit-serial reverse-carry addition: bit 14 first, carry moves to lower bits.
  function automatic logic [14:0] rc_add(input logic [14:0] a, input logic [14:0] b);
    logic [14:0] s;
    logic c;
    c = 1'b0;
    for (int i = 14; i >= 0; i--) begin
      s[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
    end
    return s;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (time %0t)", tag, got, exp, $time);
    end
  endtask

  // Drives one request, waits for its registered result and compares every output.
  task automatic apply(input logic [15:0] p, input int m, input bit byt, input bit wr,
                       input bit en, input logic [3:0] s, input logic [14:0] piv,
                       input logic [15:0] base);
    logic [15:0] ea, wb, step, bytes;
    logic wben, act, err, pow2;
    string tg;
    act  = en && wr && !byt && (s != 4'd15) && (m == 2 || m == 4);
    step = byt ? 16'd1 : 16'd2;
    ea = p; wb = p; wben = 1'b0;
    case (m)
      1: begin wb = p - step; wben = 1; end
      2: begin wb = p + step; wben = 1; end
      3: begin ea = p - step; wb = ea; wben = 1; end
      4: begin ea = p + step; wb = ea; wben = 1; end
      5: ea = p + in_ofs;
      default: ;
    endcase
    tg = (en && !act) ? "R2" : "R3";
    if (act) begin
      wb = {rc_add(p[15:1], piv), 1'b0};
      ea = (m == 2) ? {p[15:1], 1'b0} : wb;
      wben = 1'b1;
      tg = (m == 2) ? "R5" : "R6";
    end
    pow2 = 1'b0;
    for (int k = 0; k < 15; k++) if (piv == 15'(1 << k)) pow2 = 1'b1;
    bytes = {piv[13:0], 2'b00};
    err = act && (!pow2 || ((base & (bytes - 16'd1)) != 0));
    in_valid = 1; in_ptr = p; in_mode = 3'(m); in_is_byte = byt; in_is_write = wr;
    in_rev_en = en; in_sel = s; in_pivot = piv; in_buf_base = base;
    @(posedge clk); #1;
    chk({tg, " ea"}, out_ea, ea);
    chk({tg, " wb"}, out_wb, wb);
    chk({tg, " wb_en"}, 16'(out_wb_en), 16'(wben));
    chk("R1 active", 16'(out_rev_active), 16'(act));
    chk("R8 inhibit", 16'(out_mod_inhibit), 16'(act));
    chk("R9 cfg_err", 16'(out_cfg_err), 16'(err));
    chk("R10 valid", 16'(out_valid), 16'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] ptr;
    logic [3:0] r;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset valid", 16'(out_valid), 16'd0);
    chk("R10 reset ea", out_ea, 16'd0);
    chk("R10 reset wb", out_wb, 16'd0);
    chk("R10 reset flags", {13'd0, out_wb_en, out_rev_active, out_cfg_err}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    in_ofs = 16'h0010;
    // R1 R2 R3 R5 R6: sweep of pointers, modes, sizes, directions, enables, selectors
    for (int p = 0; p < 128; p++)
      for (int m = 0; m < 6; m++)
        for (int b = 0; b < 2; b++)
          for (int w = 0; w < 2; w++)
            for (int e = 0; e < 2; e++) begin
              apply(16'(p), m, b[0], w[0], e[0], 4'd3, 15'd8, 16'h0000);
              apply(16'(p), m, b[0], w[0], e[0], 4'd15, 15'd8, 16'h0000);
            end
    // R4 R7: pivot sweep, including wrap of the high pointer bits
    for (int k = 0; k < 7; k++)
      for (int p = 0; p < 64; p++) begin
        ptr = 16'hA500 | 16'(p * 2 + 1);
        apply(ptr, 2, 0, 1, 1, 4'd5, 15'(1 << k), 16'h0000);
        chk("R7 upper bits", out_wb >> (k + 2), ptr >> (k + 2));
        apply(ptr, 4, 0, 1, 1, 4'd5, 15'(1 << k), 16'h0000);
      end
    // R9: bad pivots and misaligned bases
    apply(16'h0100, 2, 0, 1, 1, 4'd1, 15'd6, 16'h0100);
    apply(16'h0100, 2, 0, 1, 1, 4'd1, 15'd0, 16'h0100);
    apply(16'h0100, 2, 0, 1, 1, 4'd1, 15'd8, 16'h0108);
    apply(16'h0100, 2, 0, 1, 1, 4'd1, 15'd8, 16'h0120);
    apply(16'h0100, 4, 0, 1, 1, 4'd1, 15'd8, 16'h0110);
    apply(16'h0100, 2, 0, 0, 1, 4'd1, 15'd6, 16'h0101);
    // R4: chained post-increment writes visit a 16-word buffer in bit-reversed order
    ptr = 16'h0100;
    for (int i = 0; i < 16; i++) begin
      r = 4'({i[0], i[1], i[2], i[3]});
      apply(ptr, 2, 0, 1, 1, 4'd7, 15'd8, 16'h0100);
      chk("R4 fft order", out_ea, 16'h0100 + 16'(2 * r));
      ptr = out_wb;
    end
    chk("R4 fft wrap", ptr, 16'h0100);
    // R10: idle request clears valid
    in_valid = 0;
    @(posedge clk); #1;
    chk("R10 idle valid", 16'(out_valid), 16'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule